// File: doc/BRIEF.md
# Autonomous Multi-Channel Conversion Scanner

This block drives an eight-input sampling converter without software involvement. Once it is armed, it steps through a channel-enable bitmap from the lowest index to the highest. For each enabled channel it starts one conversion. When a conversion finishes, the block writes the 12-bit code into a per-channel result slot. A programmable interval timer then starts the next pass of the scan.

The converter is modelled by a behavioural stub. The stub captures the code presented for the selected channel and pulses `done` a fixed number of cycles later.

Software reaches the block through a byte-wide register port with these fields:

- a conversion-mode field;
- an interval code;
- a sequencer start bit;
- a sequence-mode field;
- the channel bitmap;
- a result-update enable.

Results are read back as two bytes per channel.

The interval is counted in prescaled ticks. `TICK_DIV` clock cycles make one tick, and interval code `k` spans `BASE_TICKS << k` ticks. The defaults give 750 µs for code 0 at 50 MHz. A test environment can shrink both parameters.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, every configuration register and every result byte reads 0x00 and no conversion strobe occurs.
- R2: Conversions run only when all three of these hold: mode register (0x01) bits [6:5] equal 1, sequencer register (0x02) bits [1:0] equal 1, and sequencer register bit 4 (start) is 1. With any other combination, no strobe is issued.
- R3: Within one pass, the enabled channels are converted in ascending index order and channels whose bitmap bit is 0 are skipped. A bitmap of 0x00 produces no conversions.
- R4: A write to the bitmap register (0x03) while the start bit is 1 does not change which channels are scanned. The new bitmap takes effect only after the start bit is cleared and set again.
- R5: The result for channel n reads at address 0xA0+2n and 0xA1+2n. Code bits [3:0] appear in bits [7:4] of the first byte, whose bits [3:0] read 0. Code bits [11:4] appear in the second byte.
- R6: A result slot is updated only when bit 5 of the general register (0x00) is 1. With that bit clear, conversions still run but the stored results are unchanged.
- R7: Consecutive pass starts are exactly `(BASE_TICKS << code) * TICK_DIV` clock cycles apart, where `code` is mode register bits [1:0]. This holds whenever a pass is shorter than the interval.
- R8: When the start bit is cleared during a pass, the conversion in flight completes and its result is stored. After that, no further strobe is issued.
- R9: Configuration registers read back the last value written, one cycle after the read address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| waddr | input | 8 | Write address |
| wdata | input | 8 | Write data |
| raddr | input | 8 | Read address |
| rdata | output | 8 | Registered read data, valid one cycle after `raddr` |
| ain_codes | input | CH*RES | Code each channel's converter stub returns, channel n at bits [n*RES +: RES] |
| conv_start_o | output | 1 | One-cycle strobe when a conversion starts |
| conv_ch_o | output | CHW | Channel of the conversion just started |

## Verification
A wrong scan pointer or a stale bitmap copy shows up on the strobe channel number within one conversion time, as an out-of-order or disabled channel. A timer that miscounts shows up in the spacing between pass starts on the first interval. A broken gate on run, stop or result-update shows up as an extra strobe one cycle after the gate falls, or as a changed result byte on the next readback after the pass.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [7:0] A_GEN  = 8'h00;
  localparam logic [7:0] A_MODE = 8'h01;
  localparam logic [7:0] A_SEQ  = 8'h02;
  localparam logic [7:0] A_MAP  = 8'h03;
  localparam logic [7:0] A_RES  = 8'hA0;
  localparam int B_STATS = 5;
  localparam int B_START = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WAIT} scan_st_t;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs import adc_seq_pkg::*; #(
  parameter int CH  = 8,
  parameter int RES = 12,
  localparam int CHW = $clog2(CH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [7:0]     waddr,
  input  logic [7:0]     wdata,
  input  logic [7:0]     raddr,
  output logic [7:0]     rdata,
  input  logic           res_we,
  input  logic [CHW-1:0] res_ch,
  input  logic [RES-1:0] res_val,
  output logic           run,
  output logic [1:0]     ival_code,
  output logic [CH-1:0]  scan_map
);
  logic [7:0] gen_q, mode_q, seq_q, map_q;
  logic [CH-1:0] shadow_q;
  logic [RES-1:0] res_q [CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q <= '0; mode_q <= '0; seq_q <= '0; map_q <= '0;
    end else if (wr_en) begin
      case (waddr)
        A_GEN:   gen_q  <= wdata;
        A_MODE:  mode_q <= wdata;
        A_SEQ:   seq_q  <= wdata;
        A_MAP:   map_q  <= wdata;
        default: ;
      endcase
    end
  end

  // bitmap copy tracks the register only while the sequencer is stopped
  always_ff @(posedge clk) begin
    if (rst) shadow_q <= '0;
    else if (!seq_q[B_START]) shadow_q <= map_q[CH-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CH; i++) res_q[i] <= '0;
    end else if (res_we && gen_q[B_STATS]) begin
      res_q[res_ch] <= res_val;
    end
  end

  logic [7:0]  ridx;
  logic [15:0] rword;
  logic [7:0]  rnext;
  always_comb begin
    ridx  = raddr - A_RES;
    rword = '0;
    rnext = '0;
    case (raddr)
      A_GEN:  rnext = gen_q;
      A_MODE: rnext = mode_q;
      A_SEQ:  rnext = seq_q;
      A_MAP:  rnext = map_q;
      default: begin
        if (raddr >= A_RES && int'(ridx) < 2*CH) begin
          rword = 16'(res_q[ridx[CHW:1]]) << 4;
          rnext = ridx[0] ? rword[15:8] : rword[7:0];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rnext;
  end

  assign run       = (mode_q[6:5] == 2'd1) && (seq_q[1:0] == 2'd1) && seq_q[B_START];
  assign ival_code = mode_q[1:0];
  assign scan_map  = shadow_q;

  p_map_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_q[B_START] && $past(seq_q[B_START])) |-> $stable(shadow_q));

  for (genvar g = 0; g < CH; g++) begin : g_chk
    p_stats_gate_r6: assert property (@(posedge clk) disable iff (rst)
      !gen_q[B_STATS] |=> $stable(res_q[g]));
  end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int TICK_DIV   = 50,
  parameter int BASE_TICKS = 750,
  localparam int PW = $clog2(TICK_DIV + 1),
  localparam int TW = $clog2((BASE_TICKS << 3) + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] code,
  output logic       expire
);
  logic [PW-1:0] pre_q;
  logic [TW-1:0] tck_q;
  logic [TW-1:0] limit;
  logic          tick;

  assign limit  = TW'(BASE_TICKS) << code;
  assign tick   = (pre_q == PW'(TICK_DIV - 1));
  assign expire = run && tick && (tck_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      pre_q <= '0;
      tck_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      tck_q <= (tck_q == limit - 1'b1) ? '0 : tck_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int CH          = 8,
  parameter int RES         = 12,
  parameter int CONV_CYCLES = 300,
  localparam int CHW = $clog2(CH),
  localparam int CW  = $clog2(CONV_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CHW-1:0]    ch_i,
  input  logic [CH*RES-1:0] ain,
  output logic              done_o,
  output logic [RES-1:0]    code_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; cnt_q <= '0; done_o <= 1'b0; code_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(CONV_CYCLES - 1);
        code_o <= ain[ch_i*RES +: RES];
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int CH = 8,
  localparam int CHW = $clog2(CH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_i,
  input  logic           expire_i,
  input  logic [CH-1:0]  map_i,
  input  logic           done_i,
  output logic           scan_go,
  output logic           conv_start,
  output logic [CHW-1:0] conv_ch,
  output logic           res_we
);
  scan_st_t       st_q;
  logic [CH-1:0]  left_q;
  logic           run_d, kick_q, run_rise;
  logic [CHW-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = CH - 1; i >= 0; i--)
      if (left_q[i]) low_idx = CHW'(i);
  end

  assign run_rise = run_i && !run_d;
  assign scan_go  = (st_q == ST_IDLE) && run_i && (kick_q || expire_i || run_rise);
  assign res_we   = (st_q == ST_WAIT) && done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; left_q <= '0; run_d <= 1'b0; kick_q <= 1'b0;
      conv_start <= 1'b0; conv_ch <= '0;
    end else begin
      run_d      <= run_i;
      conv_start <= 1'b0;
      if (!run_i || scan_go)            kick_q <= 1'b0;
      else if (run_rise || expire_i)    kick_q <= 1'b1;
      case (st_q)
        ST_IDLE: if (scan_go) begin
          left_q <= map_i;
          st_q   <= ST_SCAN;
        end
        ST_SCAN: begin
          if (!run_i || left_q == '0) begin
            st_q <= ST_IDLE;
          end else begin
            conv_start      <= 1'b1;
            conv_ch         <= low_idx;
            left_q[low_idx] <= 1'b0;
            st_q            <= ST_WAIT;
          end
        end
        ST_WAIT: if (done_i) st_q <= ST_SCAN;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_idle_unless_run_r2: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !conv_start);
  p_member_r3: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> map_i[conv_ch]);
  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH          = 8,
  parameter int RES         = 12,
  parameter int TICK_DIV    = 50,
  parameter int BASE_TICKS  = 750,
  parameter int CONV_CYCLES = 300,
  localparam int CHW = $clog2(CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        waddr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        raddr,
  output logic [7:0]        rdata,
  input  logic [CH*RES-1:0] ain_codes,
  output logic              conv_start_o,
  output logic [CHW-1:0]    conv_ch_o
);
  logic           run, expire, scan_go, done, res_we;
  logic [1:0]     code;
  logic [CH-1:0]  scan_map;
  logic [RES-1:0] conv_code;

  adc_seq_regs #(.CH(CH), .RES(RES)) u_regs (
    .clk, .rst, .wr_en, .waddr, .wdata, .raddr, .rdata,
    .res_we, .res_ch(conv_ch_o), .res_val(conv_code),
    .run, .ival_code(code), .scan_map);

  adc_seq_timer #(.TICK_DIV(TICK_DIV), .BASE_TICKS(BASE_TICKS)) u_timer (
    .clk, .rst, .run, .restart(scan_go), .code, .expire);

  adc_seq_ctrl #(.CH(CH)) u_ctrl (
    .clk, .rst, .run_i(run), .expire_i(expire), .map_i(scan_map),
    .done_i(done), .scan_go, .conv_start(conv_start_o), .conv_ch(conv_ch_o),
    .res_we);

  adc_conv_stub #(.CH(CH), .RES(RES), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk, .rst, .start_i(conv_start_o), .ch_i(conv_ch_o), .ain(ain_codes),
    .done_o(done), .code_o(conv_code));
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int CH = 8, RES = 12, TD = 2, BT = 10, CC = 5;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [7:0] waddr = 0, wdata = 0, raddr = 0, rdata;
  logic [CH*RES-1:0] ain = '0;
  logic conv_start_o;
  logic [2:0] conv_ch_o;
  int n_chk = 0, n_fail = 0;
  int log_ch [512];
  int log_t  [512];
  int log_n = 0, cyc = 0, base = 0;
  logic [RES-1:0] va [CH];

  always #10 clk = ~clk;

  adc_scan_seq #(.CH(CH), .RES(RES), .TICK_DIV(TD), .BASE_TICKS(BT), .CONV_CYCLES(CC)) dut (
    .clk, .rst, .wr_en, .waddr, .wdata, .raddr, .rdata, .ain_codes(ain),
    .conv_start_o, .conv_ch_o);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (conv_start_o && log_n < 512) begin
      log_ch[log_n] <= int'(conv_ch_o);
      log_t[log_n]  <= cyc;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; waddr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk); raddr = a;
    @(negedge clk); v = int'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ain(input int seed);
    for (int i = 0; i < CH; i++) ain[i*RES +: RES] = RES'(seed + i * 12'h1A7);
  endtask

  task automatic chk_res(input string req, input int ch, input int code);
    int lo, hi;
    rd(8'hA0 + 8'(2*ch), lo);
    rd(8'hA1 + 8'(2*ch), hi);
    chk(req, lo, (code & 'hF) << 4);
    chk(req, hi, (code >> 4) & 'hFF);
  endtask

  task automatic t_reset_r1();
    int v;
    for (int a = 0; a < 4; a++) begin rd(8'(a), v); chk("R1 cfg", v, 0); end
    for (int a = 'hA0; a < 'hB0; a++) begin rd(8'(a), v); chk("R1 result", v, 0); end
    chk("R1 no strobe", log_n, 0);
  endtask

  task automatic t_gating_r2();
    wr(8'h00, 8'h20); wr(8'h03, 8'hFF);
    base = log_n;
    wr(8'h01, 8'h03); wr(8'h02, 8'h11); idle(100);
    chk("R2 mode 0", log_n - base, 0);
    wr(8'h01, 8'h43); idle(100);
    chk("R2 mode 2", log_n - base, 0);
    wr(8'h02, 8'h10); wr(8'h01, 8'h23); idle(100);
    chk("R2 seq manual", log_n - base, 0);
    wr(8'h02, 8'h11); idle(100);
    chk("R2 all set runs", int'(log_n - base > 0), 1);
    wr(8'h02, 8'h01); idle(80);
  endtask

  task automatic t_order_r3();
    wr(8'h03, 8'hA5); wr(8'h01, 8'h23);
    base = log_n;
    wr(8'h02, 8'h11); idle(60); wr(8'h02, 8'h01); idle(20);
    chk("R3 count", log_n - base, 4);
    chk("R3 first", log_ch[base], 0);
    chk("R3 second", log_ch[base+1], 2);
    chk("R3 third", log_ch[base+2], 5);
    chk("R3 fourth", log_ch[base+3], 7);
    wr(8'h03, 8'h00);
    base = log_n;
    wr(8'h02, 8'h11); idle(200); wr(8'h02, 8'h01); idle(10);
    chk("R3 empty map", log_n - base, 0);
  endtask

  task automatic t_map_change_r4();
    wr(8'h03, 8'h01); wr(8'h01, 8'h20);
    base = log_n;
    wr(8'h02, 8'h11); idle(10); wr(8'h03, 8'h80); idle(80);
    chk("R4 scans kept going", int'(log_n - base >= 3), 1);
    for (int i = base; i < log_n; i++) chk("R4 old map used", log_ch[i], 0);
    wr(8'h02, 8'h01); idle(20);
    base = log_n;
    wr(8'h02, 8'h11); idle(15); wr(8'h02, 8'h01); idle(20);
    chk("R4 new map after restart", log_ch[base], 7);
  endtask

  task automatic t_format_r5_r6();
    set_ain(12'hA5C);
    for (int i = 0; i < CH; i++) va[i] = ain[i*RES +: RES];
    wr(8'h00, 8'h20); wr(8'h03, 8'hFF); wr(8'h01, 8'h23);
    wr(8'h02, 8'h11); idle(100); wr(8'h02, 8'h01); idle(20);
    for (int i = 0; i < CH; i++) chk_res("R5 byte layout", i, int'(va[i]));
    set_ain(12'h3E1);
    wr(8'h00, 8'h00);
    base = log_n;
    wr(8'h02, 8'h11); idle(100); wr(8'h02, 8'h01); idle(20);
    chk("R6 conversions ran", log_n - base, 8);
    for (int i = 0; i < CH; i++) chk_res("R6 result unchanged", i, int'(va[i]));
  endtask

  task automatic t_interval_r7(input int code);
    int per;
    per = (BT << code) * TD;
    wr(8'h03, 8'h01); wr(8'h01, 8'(8'h20 | code));
    base = log_n;
    wr(8'h02, 8'h11); idle(3 * per + 20); wr(8'h02, 8'h01); idle(20);
    chk("R7 pass count", int'(log_n - base >= 3), 1);
    chk("R7 spacing a", log_t[base+1] - log_t[base], per);
    chk("R7 spacing b", log_t[base+2] - log_t[base+1], per);
  endtask

  task automatic t_stop_r8();
    int guard_n;
    set_ain(12'h6D2);
    wr(8'h00, 8'h20); wr(8'h03, 8'hFF); wr(8'h01, 8'h23);
    base = log_n;
    wr(8'h02, 8'h11);
    guard_n = 0;
    while (log_n - base < 3 && guard_n < 200) begin @(negedge clk); guard_n++; end
    wr(8'h02, 8'h01); idle(60);
    chk("R8 no strobe after stop", log_n - base, 3);
    chk_res("R8 in-flight stored", 2, int'(ain[2*RES +: RES]));
    chk_res("R8 later channel untouched", 3, int'(va[3]));
  endtask

  task automatic t_readback_r9();
    int v;
    wr(8'h03, 8'h5A); rd(8'h03, v); chk("R9 map", v, 'h5A);
    wr(8'h01, 8'h62); rd(8'h01, v); chk("R9 mode", v, 'h62);
    rd(8'h02, v); chk("R9 seq", v, 'h01);
    rd(8'h00, v); chk("R9 gen", v, 'h20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(4); rst = 0; idle(2);
    t_reset_r1();
    t_gating_r2();
    t_order_r3();
    t_map_change_r4();
    t_format_r5_r6();
    t_interval_r7(1);
    t_interval_r7(2);
    t_stop_r8();
    t_readback_r9();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule